// File: doc/BRIEF.md
# Serial-Stepped Wiper Position Controller

This block is the digital control section of a 100-tap stepped potentiometer. Three slow control lines come in from outside: an active-low select, a step strobe and a direction level. They are brought into the clock domain through a two-flop synchronizer. While the block is selected, each falling edge of the strobe moves a wiper position counter one tap toward the upper or the lower end. The counter stops at both ends. The position is given out in binary and also as a registered one-hot select over the 100 tap lines.

A shadow register stands in for the non-volatile cell. The block copies the position into it when select is released while the strobe is high. Releasing select while the strobe is low deselects the block without a copy. A copy holds the block busy for a fixed number of cycles and then leaves it in standby until select is asserted again. Reset does not clear the shadow register. Reset loads the counter from it, so the stored position survives a reset. The shadow register powers up holding a parameter value.

Top module: `wiper_step_ctrl`

## Requirements
- R1: The position runs from 0 to NUM_TAPS-1 (0 to 99) and appears in binary on `pos_o`; at power-up the shadow register holds INIT_POS, and reset loads that value into the position.
- R2: `tap_sel_o` has exactly one bit set after reset, at bit index equal to the position; it follows a position change one clock later.
- R3: While selected, a falling edge on `step_i` moves the position by one: up when `dir_i` is 1, down when `dir_i` is 0; `pos_o` shows the new value three clock edges after the strobe falls.
- R4: Strobe edges while `cs_n_i` is high leave the position unchanged.
- R5: The position saturates: an up step at 99 leaves 99, a down step at 0 leaves 0.
- R6: A low-to-high change of `cs_n_i` while `step_i` is high copies the position into the shadow register and raises `busy_o` for exactly STORE_CYCLES cycles; strobe edges during that time are ignored even if select is asserted again.
- R7: A low-to-high change of `cs_n_i` while `step_i` is low stores nothing; `busy_o` stays low and the shadow register keeps its earlier value.
- R8: When a store ends, `standby_o` goes high and stays high until `cs_n_i` is seen low; it drops within a few cycles after that.
- R9: Reset leaves the shadow register untouched, so the position after a reset equals the last stored position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; recalls the stored position |
| cs_n_i | input | 1 | Active-low select, asynchronous |
| step_i | input | 1 | Step strobe, acts on falling edge, asynchronous |
| dir_i | input | 1 | Step direction: 1 up, 0 down |
| pos_o | output | 7 | Wiper position, binary |
| tap_sel_o | output | 100 | One-hot tap select, registered |
| standby_o | output | 1 | High in low-power standby after a store |
| busy_o | output | 1 | High while a store is in progress |

## Verification
The hardest case to reach from the ports is a strobe edge that arrives during the store window while the block is already selected again. Only then does the busy state block the step, and not the select level. The bench reaches it with a directed sequence. It waits until `busy_o` is seen high, pulls select low at once and fires a strobe edge well inside the window. It then checks that the position has not moved. A deselect without a store needs the strobe low when select rises, and that low edge is itself a step. The bench model therefore counts that step before it checks that the stored value did not change across a later reset.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  typedef enum logic [1:0] {
    ST_DESEL = 2'd0,
    ST_SEL   = 2'd1,
    ST_BUSY  = 2'd2,
    ST_STBY  = 2'd3
  } wsc_state_e;
endpackage

// File: rtl/wsc_sync.sv
module wsc_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/wsc_counter.sv
module wsc_counter #(
  parameter int NUM_TAPS = 100,
  parameter int POS_W    = $clog2(NUM_TAPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [POS_W-1:0] load_i,
  input  logic             en_i,
  input  logic             up_i,
  output logic [POS_W-1:0] count_o
);
  localparam logic [POS_W-1:0] TOP = POS_W'(NUM_TAPS - 1);

  logic [POS_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= load_i;
    end else if (en_i) begin
      if (up_i && count_q != TOP)        count_q <= count_q + POS_W'(1);
      else if (!up_i && count_q != '0)   count_q <= count_q - POS_W'(1);
    end
  end

  assign count_o = count_q;

  assert_in_range_R1: assert property (@(posedge clk) disable iff (rst)
    count_q <= TOP);
  assert_sat_top_R5: assert property (@(posedge clk) disable iff (rst)
    (en_i && up_i && count_q == TOP) |=> count_q == TOP);
  assert_sat_bottom_R5: assert property (@(posedge clk) disable iff (rst)
    (en_i && !up_i && count_q == '0) |=> count_q == '0);
  assert_step_up_R3: assert property (@(posedge clk) disable iff (rst)
    (en_i && up_i && count_q < TOP) |=> count_q == $past(count_q) + POS_W'(1));
endmodule

// File: rtl/wsc_decode.sv
module wsc_decode #(
  parameter int NUM_TAPS = 100,
  parameter int POS_W    = $clog2(NUM_TAPS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [POS_W-1:0]    pos_i,
  output logic [NUM_TAPS-1:0] tap_o
);
  logic [NUM_TAPS-1:0] dec;
  logic [NUM_TAPS-1:0] tap_q;

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    assign dec[i] = (pos_i == POS_W'(i));
  end

  always_ff @(posedge clk) tap_q <= dec;

  assign tap_o = tap_q;

  assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(tap_q) == 1);
endmodule

// File: rtl/wiper_step_ctrl.sv
module wiper_step_ctrl
  import wsc_pkg::*;
#(
  parameter int NUM_TAPS     = 100,
  parameter int SYNC_STAGES  = 2,
  parameter int STORE_CYCLES = 8,
  parameter int INIT_POS     = 0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cs_n_i,
  input  logic                      step_i,
  input  logic                      dir_i,
  output logic [$clog2(NUM_TAPS)-1:0] pos_o,
  output logic [NUM_TAPS-1:0]       tap_sel_o,
  output logic                      standby_o,
  output logic                      busy_o
);
  localparam int POS_W = $clog2(NUM_TAPS);
  localparam int CNT_W = $clog2(STORE_CYCLES + 1);

  logic [2:0]       raw_in, syn_in;
  logic             s_cs_n, s_step, s_dir;
  logic             step_prev_q;
  logic             step_fall, step_en;
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] shadow_q = POS_W'(INIT_POS);
  logic [CNT_W-1:0] busy_cnt_q;
  wsc_state_e       state_q;

  assign raw_in = {cs_n_i, step_i, dir_i};

  wsc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_in),
    .q_o (syn_in)
  );

  assign {s_cs_n, s_step, s_dir} = syn_in;

  always_ff @(posedge clk) begin
    if (rst) step_prev_q <= 1'b1;
    else     step_prev_q <= s_step;
  end

  assign step_fall = step_prev_q && !s_step;
  assign step_en   = step_fall && !s_cs_n && (state_q == ST_SEL);

  // Select / store / standby sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_DESEL;
      busy_cnt_q <= '0;
    end else begin
      case (state_q)
        ST_DESEL, ST_STBY: if (!s_cs_n) state_q <= ST_SEL;
        ST_SEL: if (s_cs_n) begin
          if (s_step) begin
            state_q    <= ST_BUSY;
            busy_cnt_q <= CNT_W'(STORE_CYCLES - 1);
          end else begin
            state_q <= ST_DESEL;
          end
        end
        ST_BUSY: begin
          if (busy_cnt_q == '0) state_q <= ST_STBY;
          else                  busy_cnt_q <= busy_cnt_q - CNT_W'(1);
        end
        default: state_q <= ST_DESEL;
      endcase
    end
  end

  // Shadow storage: never cleared by reset
  always_ff @(posedge clk) begin
    if (!rst && state_q == ST_SEL && s_cs_n && s_step) shadow_q <= pos;
  end

  wsc_counter #(.NUM_TAPS(NUM_TAPS), .POS_W(POS_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .load_i  (shadow_q),
    .en_i    (step_en),
    .up_i    (s_dir),
    .count_o (pos)
  );

  wsc_decode #(.NUM_TAPS(NUM_TAPS), .POS_W(POS_W)) u_dec (
    .clk   (clk),
    .rst   (rst),
    .pos_i (pos),
    .tap_o (tap_sel_o)
  );

  assign pos_o     = pos;
  assign busy_o    = (state_q == ST_BUSY);
  assign standby_o = (state_q == ST_STBY);

  assert_desel_hold_R4: assert property (@(posedge clk) disable iff (rst)
    s_cs_n |=> $stable(pos));
  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> $stable(pos));
  assert_store_value_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> shadow_q == pos);
  assert_standby_entry_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(standby_o) |-> $past(busy_o));
  assert_no_store_R7: assert property (@(posedge clk) disable iff (rst)
    !busy_o |=> (busy_o || $stable(shadow_q)));
  assert_recall_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> pos == shadow_q);
endmodule

// File: tb/test_wiper_step_ctrl.sv
`timescale 1ns/1ps
module test_wiper_step_ctrl;
  localparam int NT   = 100;
  localparam int PW   = 7;
  localparam int SC   = 8;
  localparam int INIT = 42;

  logic          clk = 1'b0;
  logic          rst, cs_n, step, dir;
  logic [PW-1:0] pos;
  logic [NT-1:0] tap;
  logic          stby, busy;

  int n_chk = 0, n_bad = 0;
  int exp_pos, exp_shadow;
  bit selected, done;

  always #2 clk = ~clk;

  wiper_step_ctrl #(.NUM_TAPS(NT), .SYNC_STAGES(2), .STORE_CYCLES(SC),
                    .INIT_POS(INIT)) i_wiper_step_ctrl (
    .clk(clk), .rst(rst), .cs_n_i(cs_n), .step_i(step), .dir_i(dir),
    .pos_o(pos), .tap_sel_o(tap), .standby_o(stby), .busy_o(busy));

  function automatic logic [NT-1:0] onehot_of(int p);
    logic [NT-1:0] v = '0;
    v[p] = 1'b1;
    return v;
  endfunction

  function automatic int next_pos(int p, bit up);
    if (up) return (p == NT-1) ? p : p + 1;
    return (p == 0) ? 0 : p - 1;
  endfunction

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic chk_pos(string req);
    chk(req, int'(pos), exp_pos);
    n_chk++;
    if (tap !== onehot_of(exp_pos)) begin
      n_bad++;
      $display("FAIL R2 (%s): actual tap %h expected %h", req, tap, onehot_of(exp_pos));
    end
  endtask

  task automatic do_select();
    cs_n = 1'b0; wait_cyc(6);
    selected = 1;
  endtask

  task automatic do_step(bit up, string req);
    dir = up; wait_cyc(1);
    step = 1'b0; wait_cyc(5);
    exp_pos = next_pos(exp_pos, up);
    chk_pos(req);
    step = 1'b1; wait_cyc(4);
  endtask

  task automatic do_store();
    cs_n = 1'b1;
    exp_shadow = exp_pos;
    wait_cyc(3 + SC - 1);
    chk("R6 busy during store", int'(busy), 1);
    wait_cyc(1);
    chk("R6 busy ends", int'(busy), 0);
    chk("R8 standby after store", int'(stby), 1);
    wait_cyc(4);
    chk("R8 standby held", int'(stby), 1);
    selected = 0;
  endtask

  task automatic do_nostore(bit up);
    dir = up; wait_cyc(1);
    step = 1'b0; wait_cyc(5);
    exp_pos = next_pos(exp_pos, up);
    cs_n = 1'b1; wait_cyc(4);
    chk("R7 no busy", int'(busy), 0);
    step = 1'b1; wait_cyc(4);
    selected = 0;
    step = 1'b0; wait_cyc(5);
    chk_pos("R4 strobe ignored deselected");
    step = 1'b1; wait_cyc(5);
    chk_pos("R4 strobe ignored deselected");
  endtask

  task automatic do_reset();
    rst = 1'b1; wait_cyc(3);
    rst = 1'b0; wait_cyc(1);
    exp_pos = exp_shadow;
    chk_pos("R9 recall after reset");
    wait_cyc(5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int op;
    void'($urandom(32'd20240611));
    done = 0;
    rst = 1'b1; cs_n = 1'b1; step = 1'b1; dir = 1'b0;
    exp_shadow = INIT; exp_pos = INIT; selected = 0;
    wait_cyc(4);
    rst = 1'b0; wait_cyc(1);
    chk_pos("R1 reset position");
    chk("R8 not standby at reset", int'(stby), 0);
    chk("R6 not busy at reset", int'(busy), 0);

    do_select();
    do_step(1'b1, "R3 up");
    do_step(1'b0, "R3 down");
    // Saturation corners
    for (int i = 0; i < 60; i++) do_step(1'b1, "R5 climb");
    chk_pos("R5 saturate at top");
    do_step(1'b1, "R5 up at top");
    for (int i = 0; i < 102; i++) do_step(1'b0, "R5 descend");
    do_step(1'b0, "R5 down at bottom");
    for (int i = 0; i < 17; i++) do_step(1'b1, "R3 up");

    // Store, then strobe during busy with select asserted again
    cs_n = 1'b1;
    exp_shadow = exp_pos;
    wait_cyc(3);
    chk("R6 busy seen", int'(busy), 1);
    cs_n = 1'b0; dir = 1'b1; wait_cyc(1);
    step = 1'b0; wait_cyc(2);
    step = 1'b1; wait_cyc(SC + 4);
    chk_pos("R6 step ignored while busy");
    chk("R8 standby cleared by select", int'(stby), 0);
    selected = 1;

    // No-store deselect then reset keeps the earlier stored value
    do_nostore(1'b1);
    chk("R8 no standby without store", int'(stby), 0);
    do_reset();
    chk("R9 shadow kept", exp_pos, 17);
    do_select();
    do_step(1'b1, "R3 after recall");
    do_store();
    do_select();
    chk("R8 standby left", int'(stby), 0);

    // Constrained random walk
    for (int k = 0; k < 400; k++) begin
      if (!selected) do_select();
      op = int'($urandom_range(0, 19));
      if (op < 9)       do_step(1'b1, "R3 random up");
      else if (op < 17) do_step(1'b0, "R3 random down");
      else if (op == 17) do_nostore(1'($urandom_range(0, 1)));
      else if (op == 18) do_store();
      else begin
        if ($urandom_range(0, 3) == 0) do_reset();
        else do_step(1'b1, "R3 random up");
      end
    end
    do_reset();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule